// File: doc/BRIEF.md
# RTC Seconds Counter with Alarm

A real-time clock core for a memory-mapped peripheral space. A prescaler divides a 32768 Hz time-base strobe into one-second steps. Each step advances a seconds counter, and the counter is compared against one alarm value. A match sets a sticky status flag, and that flag feeds an interrupt line. The interrupt can be gated by an alarm enable and by a mask bit.

Software uses a 32-bit register bus with byte addresses. It starts and stops the clock, loads the counter, sets the alarm and services the interrupt by writing one to a clear register. A build-time option stores the counter in Gray code. In that mode software writes and reads Gray-coded load, alarm and time values. A separate step input lets external trim logic insert an extra second.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, the status reads 0, the interrupt mask reads 1 and irq_o is 0.
- R2: Control register bits are alarm enable (bit 0), oscillator select (bit 8) and run (bit 12), at byte address 0x00. All other control bits read 0. The alarm register at 0x08 and mask bit 0 at 0x20 read back what was written.
- R3: While run is 1, the counter advances by one second after every 2^PRESC_W cycles with tick_i high. While run is 0, tick_i has no effect on either the counter or the prescaler.
- R4: A write to 0x04 sets the counter on the next cycle and restarts the prescaler. It works whether run is 0 or 1, and it takes priority over a second step in the same cycle.
- R5: A pulse on sec_step_i advances the counter by one second when run is 1. The pulse is ignored when run is 0.
- R6: In binary mode a step adds 1, and 0xFFFFFFFF wraps to 0. The running count reads at 0x34 and also at 0x04.
- R7: In Gray mode the counter holds gray = bin ^ (bin >> 1). A step moves it to the Gray code of the next binary value.
- R8: Status bit 0 at 0x30 sets only when alarm enable is 1 and a second step brings the counter to a value equal to the alarm register. A load never sets it.
- R9: Status stays set until a write to 0x24 with bit 0 at 1. A write with bit 0 at 0 has no effect. A match in the same cycle as a clear leaves status set.
- R10: irq_o is 1 exactly when status is 1, alarm enable is 1 and the mask bit is 0.
- R11: Address 0x24 and any unmapped address read as 0.
- R12: osc_sel_o follows control bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at the 32768 Hz time-base rate |
| sec_step_i | input | 1 | Extra one-second step from trim logic |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write when 1 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |
| irq_o | output | 1 | Alarm interrupt |
| osc_sel_o | output | 1 | Oscillator source select |

## Verification
The hardest case to reach is a clear that arrives in the very cycle an alarm match is detected. The bench gets there by preloading the counter to one below the alarm. It then drives the clear write and a sec_step_i pulse on the same edge. The prescaler phase is reached by loading the counter partway through a second, then counting strobes up to one short of the carry and one past it. A second instance built in Gray mode receives the same writes, so each load-and-step vector checks both codings together, including the all-ones wrap.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_LOAD   = 'h04;
  localparam int unsigned OFS_ALARM  = 'h08;
  localparam int unsigned OFS_MASK   = 'h20;
  localparam int unsigned OFS_CLEAR  = 'h24;
  localparam int unsigned OFS_STATUS = 'h30;
  localparam int unsigned OFS_TIME   = 'h34;

  localparam int unsigned BIT_ALM_EN = 0;
  localparam int unsigned BIT_OSC    = 8;
  localparam int unsigned BIT_RUN    = 12;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRESC_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic clear_i,
  output logic carry_o
);
  logic [PRESC_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (clear_i)         div_q <= '0;
    else if (run_i && tick_i) div_q <= div_q + 1'b1;
  end

  assign carry_o = run_i && tick_i && !clear_i && (div_q == '1);

  AST_PRESC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !clear_i |=> $stable(div_q)); // R3
  AST_PRESC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> div_q == '0); // R3
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned W    = 32,
  parameter bit          GRAY = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] bin2gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] gray2bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  generate
    if (GRAY) begin : g_gray
      assign cnt_nxt_o = bin2gray(gray2bin(cnt_q) + 1'b1);
    end else begin : g_bin
      assign cnt_nxt_o = cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R4

  generate
    if (GRAY) begin : g_chk_gray
      AST_GRAY_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !load_i |=> $countones(cnt_q ^ $past(cnt_q)) == 1); // R7
    end else begin : g_chk_bin
      AST_BIN_PLUS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !load_i |=> cnt_q == $past(cnt_q) + W'(1)); // R6
    end
  endgenerate
endmodule

// File: rtl/rtc_alarm_status.sv
module rtc_alarm_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         arm_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] alarm_i,
  input  logic         clr_i,
  output logic         status_o
);
  logic hit;
  logic status_q;

  assign hit = step_i && arm_i && (cnt_nxt_i == alarm_i);

  // a fresh hit beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= hit || (status_q && !clr_i);
  end

  assign status_o = status_q;

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q && !clr_i |=> status_q); // R9
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit |=> !status_q); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_q && !(step_i && arm_i) |=> !status_q); // R8
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_core_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned PRESC_W = 15,
  parameter bit          GRAY    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sec_step_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              osc_sel_o
);
  logic              alm_en_q, osc_q, run_q, mask_q;
  logic [DATA_W-1:0] alarm_q;
  logic [DATA_W-1:0] cnt, cnt_nxt;
  logic              wr, wr_ctrl, wr_load, wr_alarm, wr_mask, clr;
  logic              carry, sec_adv, status;

  assign wr       = req_i && we_i;
  assign wr_ctrl  = wr && (addr_i == ADDR_W'(OFS_CTRL));
  assign wr_load  = wr && (addr_i == ADDR_W'(OFS_LOAD));
  assign wr_alarm = wr && (addr_i == ADDR_W'(OFS_ALARM));
  assign wr_mask  = wr && (addr_i == ADDR_W'(OFS_MASK));
  assign clr      = wr && (addr_i == ADDR_W'(OFS_CLEAR)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_en_q <= 1'b0;
      osc_q    <= 1'b0;
      run_q    <= 1'b0;
      mask_q   <= 1'b1;
      alarm_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        alm_en_q <= wdata_i[BIT_ALM_EN];
        osc_q    <= wdata_i[BIT_OSC];
        run_q    <= wdata_i[BIT_RUN];
      end
      if (wr_alarm) alarm_q <= wdata_i;
      if (wr_mask)  mask_q  <= wdata_i[0];
    end
  end

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .tick_i  (tick_i),
    .clear_i (wr_load),
    .carry_o (carry)
  );

  // load wins over any second step in the same cycle
  assign sec_adv = run_q && (carry || sec_step_i) && !wr_load;

  rtc_sec_counter #(.W(DATA_W), .GRAY(GRAY)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_load),
    .load_val_i (wdata_i),
    .step_i     (sec_adv),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt)
  );

  rtc_alarm_status #(.W(DATA_W)) u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (sec_adv),
    .arm_i     (alm_en_q),
    .cnt_nxt_i (cnt_nxt),
    .alarm_i   (alarm_q),
    .clr_i     (clr),
    .status_o  (status)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_CTRL): begin
        rdata_o[BIT_ALM_EN] = alm_en_q;
        rdata_o[BIT_OSC]    = osc_q;
        rdata_o[BIT_RUN]    = run_q;
      end
      ADDR_W'(OFS_LOAD),
      ADDR_W'(OFS_TIME):   rdata_o = cnt;
      ADDR_W'(OFS_ALARM):  rdata_o = alarm_q;
      ADDR_W'(OFS_MASK):   rdata_o[0] = mask_q;
      ADDR_W'(OFS_STATUS): rdata_o[0] = status;
      default:             rdata_o = '0;
    endcase
  end

  assign irq_o     = status && alm_en_q && !mask_q;
  assign osc_sel_o = osc_q;

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !wr_load |=> $stable(cnt)); // R5
  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> mask_q == $past(wdata_i[0])); // R2
endmodule

// File: tb/rtc_alarm_core_test.sv
`timescale 1ns/1ps
module rtc_alarm_core_test;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;
  localparam int unsigned PW = 4;
  localparam int unsigned SEC = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, step = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_b, rd_g;
  logic irq_b, irq_g, osc_b, osc_g;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_core #(.DATA_W(DW), .ADDR_W(AW), .PRESC_W(PW), .GRAY(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sec_step_i(step),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_b), .irq_o(irq_b), .osc_sel_o(osc_b));

  rtc_alarm_core #(.DATA_W(DW), .ADDR_W(AW), .PRESC_W(PW), .GRAY(1'b1)) uut_gray (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sec_step_i(step),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_g), .irq_o(irq_g), .osc_sel_o(osc_g));

  localparam logic [DW-1:0] VEC [6] = '{32'h0, 32'h1, 32'h7, 32'h1234_5678,
                                        32'h7FFF_FFFF, 32'hFFFF_FFFF};

  function automatic logic [DW-1:0] gray(input logic [DW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s = 1'b0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; step = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0; step = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00); chk("R1 ctrl", rd_b, 0);
    rd(8'h34); chk("R1 count", rd_b, 0);
    rd(8'h30); chk("R1 status", rd_b, 0);
    rd(8'h20); chk("R1 mask", rd_b, 1);
    chk("R1 irq", irq_b, 0);

    // R2 / R12 register readback
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00); chk("R2 ctrl bits", rd_b, 32'h0000_1101);
    chk("R12 osc_sel high", osc_b, 1);
    wr(8'h00, 32'h0);
    chk("R12 osc_sel low", osc_b, 0);
    wr(8'h08, 32'hA5A5_5A5A);
    rd(8'h08); chk("R2 alarm", rd_b, 32'hA5A5_5A5A);

    // R11 unmapped and clear register
    rd(8'h10); chk("R11 unmapped", rd_b, 0);
    rd(8'h24); chk("R11 clear reads 0", rd_b, 0);

    // R3 / R5 stopped counter ignores ticks and steps
    ticks(40);
    rd(8'h34); chk("R3 ticks ignored while stopped", rd_b, 0);
    pulse();
    rd(8'h34); chk("R5 step ignored while stopped", rd_b, 0);

    // R4 load while stopped
    wr(8'h04, 32'd5);
    rd(8'h34); chk("R4 load while stopped", rd_b, 5);

    // R3 prescaler
    wr(8'h00, 32'h1000);
    wr(8'h04, 32'h0);
    ticks(SEC - 1);
    rd(8'h34); chk("R3 one tick short", rd_b, 0);
    ticks(1);
    rd(8'h34); chk("R3 binary one second", rd_b, 1);
    chk("R7 gray one second", rd_g, gray(1));
    ticks(2 * SEC);
    rd(8'h34); chk("R3 binary three seconds", rd_b, 3);
    chk("R7 gray three seconds", rd_g, gray(3));
    rd(8'h04); chk("R6 count at load address", rd_b, 3);

    // R4 load restarts prescaler phase
    ticks(10);
    wr(8'h04, 32'h0);
    ticks(SEC - 1);
    rd(8'h34); chk("R4 prescaler restarted", rd_b, 0);
    ticks(1);
    rd(8'h34); chk("R4 second after restart", rd_b, 1);

    // R6 / R7 vector table
    foreach (VEC[i]) begin
      wr(8'h04, gray(VEC[i]));
      pulse();
      rd(8'h34);
      chk("R6 binary step", rd_b, gray(VEC[i]) + 32'd1);
      chk("R7 gray step", rd_g, gray(VEC[i] + 32'd1));
    end
    wr(8'h04, 32'hFFFF_FFFF);
    pulse();
    rd(8'h34); chk("R6 binary wrap", rd_b, 0);

    // R5 step while running
    pulse();
    rd(8'h34); chk("R5 step while running", rd_b, 1);

    // R4 load wins over same-cycle step
    wr(8'h04, 32'd100, 1'b1);
    rd(8'h34); chk("R4 load beats step", rd_b, 100);

    // R8 alarm matching
    wr(8'h08, 32'd10);
    wr(8'h04, 32'd9);
    pulse();
    rd(8'h30); chk("R8 no status when alarm disabled", rd_b, 0);
    wr(8'h00, 32'h1001);
    wr(8'h04, 32'd10);
    rd(8'h30); chk("R8 load does not match", rd_b, 0);
    wr(8'h04, 32'd9);
    pulse();
    rd(8'h30); chk("R8 match sets status", rd_b, 1);

    // R10 interrupt gating
    chk("R10 masked irq", irq_b, 0);
    wr(8'h20, 32'h0);
    chk("R10 irq unmasked", irq_b, 1);
    wr(8'h00, 32'h1000);
    chk("R10 irq off with alarm disabled", irq_b, 0);
    wr(8'h00, 32'h1001);
    chk("R10 irq back on", irq_b, 1);

    // R9 sticky status and clear
    pulse();
    rd(8'h30); chk("R9 sticky after mismatch", rd_b, 1);
    wr(8'h24, 32'h0);
    rd(8'h30); chk("R9 clear with zero ignored", rd_b, 1);
    wr(8'h24, 32'h1);
    rd(8'h30); chk("R9 clear", rd_b, 0);
    chk("R10 irq after clear", irq_b, 0);
    wr(8'h04, 32'd9);
    wr(8'h24, 32'h1, 1'b1);
    rd(8'h30); chk("R9 match beats clear", rd_b, 1);
    chk("R10 irq after race", irq_b, 1);

    report();
  end
endmodule